// File: doc/BRIEF.md
# Prescaled Interval Timer

The block is an 8-bit down-counting interval timer controlled by register strobes. A timer write does three things in one clock. It loads the start count. It picks one of four prescale ratios from a 2-bit select. It clears the timer interrupt flag. The count then drops by one every prescale period.

When a decrement would take the count below zero, the count becomes 0xFF and the interrupt flag is set. The timer then enters a wrapped mode in which it decrements on every clock, whatever the ratio. A read strobe on the count returns the timer to prescaled counting and clears the flag. The flag is left set if underflow happens on that same clock.

The block has three outputs: the current count, an interrupt byte carrying the flag, and the number of clocks until the count next changes. Bus decoding, I/O ports and memory live in other blocks.

Top module: `interval_timer`

## Requirements
- R1: `tmr_sel_i` chooses the prescale ratio on a timer write: 0 gives 1 clock, 1 gives 8, 2 gives 64 and 3 gives 1024 clocks per decrement.
- R2: A timer write loads `tmr_wdata_i` into the count, leaves wrapped mode and clears the interrupt flag; the new count is visible after that edge.
- R3: After a timer write the first decrement happens on the next clock edge, and further decrements follow every ratio clocks.
- R4: A decrement from 0 in prescaled mode gives a count of 0xFF, sets the interrupt flag and enters wrapped mode.
- R5: In wrapped mode the count decrements by one on every clock and wraps modulo 256.
- R6: A count read (`cnt_rd_i`) leaves wrapped mode. The count still changes on the read edge. After that it decrements at the selected ratio, and the prescale phase is not disturbed by the read.
- R7: A count read clears the interrupt flag, unless underflow happens on the same clock edge, in which case the flag stays set.
- R8: After reset the count is 0x00, the flag is clear, the ratio is 1024 and the prescale phase is 0, so `clocks_left_o` reads 1024 and the first underflow comes on the 1024th edge.
- R9: `clocks_left_o` is 1 in wrapped mode; otherwise it is the ratio minus the current prescale phase.
- R10: The interrupt flag appears on bit 7 of `irq_o`; bits 6 to 0 are always 0.
- R11: When a timer write and a count read fall on the same edge, the write takes effect and the flag ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_wr_i | input | 1 | Timer write strobe |
| tmr_sel_i | input | 2 | Prescale ratio select, sampled on a write |
| tmr_wdata_i | input | 8 | Start count, sampled on a write |
| cnt_rd_i | input | 1 | Count read strobe |
| count_o | output | 8 | Current count |
| irq_o | output | 8 | Interrupt byte, timer flag on bit 7 |
| clocks_left_o | output | 11 | Clocks until the next count change |

## Verification
The bench builds the timer with its default shifts of 0, 3, 6 and 10. The divide-by-1 ratio is swept over all 256 start values. The divide-by-8 ratio is swept over 32 start values and divide-by-64 over 8, and every cycle up to and past underflow is compared with a closed-form expected count, flag and remaining-clock value. The 1024 ratio is reached through the reset path and through two short loads, which keeps the full-period walk short. Directed sequences then place reads before underflow, on the underflow edge and during wrapped mode, and overlap writes with reads.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned NUM_RATIOS = 4;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler
  import itmr_pkg::*;
#(
  parameter int unsigned SHIFT0 = 0,
  parameter int unsigned SHIFT1 = 3,
  parameter int unsigned SHIFT2 = 6,
  parameter int unsigned SHIFT3 = 10,
  parameter int unsigned PH_W   = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [1:0]      sel_i,
  output logic            tick_o,
  output logic [PH_W-1:0] phase_o,
  output logic [PH_W-1:0] mask_o
);
  localparam int unsigned SHIFTS [NUM_RATIOS] = '{SHIFT0, SHIFT1, SHIFT2, SHIFT3};

  logic [PH_W-1:0] mask_tab [NUM_RATIOS];
  logic [1:0]      sel_q;
  logic [PH_W-1:0] phase_q;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_mask
    assign mask_tab[g] = PH_W'((64'(1) << SHIFTS[g]) - 64'(1));
  end

  assign mask_o  = mask_tab[sel_q];
  assign tick_o  = (phase_q == mask_o);
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 2'd3;
      phase_q <= '0;
    end else if (load_i) begin
      // preset so the first decrement lands one clock after the write
      sel_q   <= sel_i;
      phase_q <= mask_tab[sel_i];
    end else if (tick_o) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + PH_W'(1);
    end
  end

  // R3
  phase_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= mask_o);

  // R3
  tick_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !load_i) |=> (phase_q == '0));
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrapped_o,
  output logic             uflow_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrapped_q;

  assign uflow_o   = !load_i && !wrapped_q && tick_i && (cnt_q == '0);
  assign cnt_o     = cnt_q;
  assign wrapped_o = wrapped_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      wrapped_q <= 1'b0;
    end else if (load_i) begin
      cnt_q     <= load_val_i;
      wrapped_q <= 1'b0;
    end else begin
      if (wrapped_q || tick_i) cnt_q <= cnt_q - CNT_W'(1);
      // a read drops wrapped mode even on the underflow edge
      wrapped_q <= rd_i ? 1'b0 : (wrapped_q | uflow_o);
    end
  end

  // R2
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)) && !wrapped_q);

  // R4
  uflow_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uflow_o && !rd_i) |=> (cnt_q == '1) && wrapped_q);

  // R5
  wrapped_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrapped_q && !load_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R6
  read_unwrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !wrapped_q);

  // R3
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !wrapped_q && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/itmr_flag.sv
module itmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_clr_i,
  input  logic rd_clr_i,
  output logic flag_o
);
  logic flag_q;

  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (wr_clr_i) flag_q <= 1'b0;
    else if (set_i)    flag_q <= 1'b1;  // same-clock underflow beats read clear
    else if (rd_clr_i) flag_q <= 1'b0;
  end

  // R7
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !set_i) |=> !flag_q);

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !wr_clr_i) |=> flag_q);

  // R2
  wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr_i |=> !flag_q);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned SHIFT0   = 0,
  parameter int unsigned SHIFT1   = 3,
  parameter int unsigned SHIFT2   = 6,
  parameter int unsigned SHIFT3   = 10,
  parameter int unsigned IRQ_W    = 8,
  parameter int unsigned FLAG_BIT = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tmr_wr_i,
  input  logic [1:0]       tmr_sel_i,
  input  logic [CNT_W-1:0] tmr_wdata_i,
  input  logic             cnt_rd_i,
  output logic [CNT_W-1:0] count_o,
  output logic [IRQ_W-1:0] irq_o,
  output logic [max4(SHIFT0, SHIFT1, SHIFT2, SHIFT3):0] clocks_left_o
);
  localparam int unsigned PH_RAW = max4(SHIFT0, SHIFT1, SHIFT2, SHIFT3);
  localparam int unsigned PH_W   = (PH_RAW == 0) ? 1 : PH_RAW;
  localparam int unsigned LEFT_W = PH_RAW + 1;

  logic            tick;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] mask;
  logic            wrapped;
  logic            uflow;
  logic            flag;
  logic            rd_eff;

  assign rd_eff = cnt_rd_i && !tmr_wr_i;

  itmr_prescaler #(
    .SHIFT0(SHIFT0), .SHIFT1(SHIFT1), .SHIFT2(SHIFT2), .SHIFT3(SHIFT3), .PH_W(PH_W)
  ) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_wr_i),
    .sel_i   (tmr_sel_i),
    .tick_o  (tick),
    .phase_o (phase),
    .mask_o  (mask)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_wr_i),
    .load_val_i (tmr_wdata_i),
    .tick_i     (tick),
    .rd_i       (rd_eff),
    .cnt_o      (count_o),
    .wrapped_o  (wrapped),
    .uflow_o    (uflow)
  );

  itmr_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (uflow),
    .wr_clr_i (tmr_wr_i),
    .rd_clr_i (rd_eff),
    .flag_o   (flag)
  );

  for (genvar b = 0; b < IRQ_W; b++) begin : g_irq
    if (b == FLAG_BIT) begin : g_flag
      assign irq_o[b] = flag;
    end else begin : g_zero
      assign irq_o[b] = 1'b0;
    end
  end

  logic [LEFT_W-1:0] left_pre;
  assign left_pre = LEFT_W'(mask) + LEFT_W'(1) - LEFT_W'(phase);
  assign clocks_left_o = wrapped ? LEFT_W'(1) : left_pre;

  // R9
  left_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clocks_left_o != '0);

  // R9
  left_one_at_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> (clocks_left_o == LEFT_W'(1)));

  // R10
  irq_only_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) <= 1);

  // R11
  wr_over_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_wr_i && cnt_rd_i) |=> (irq_o[FLAG_BIT] == 1'b0) && (count_o == $past(tmr_wdata_i)));
endmodule

// File: tb/interval_timer_tb_top.sv
`timescale 1ns/1ps
module interval_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [7:0]  wdata = 8'd0;
  logic        rd = 1'b0;
  logic [7:0]  count;
  logic [7:0]  irq;
  logic [10:0] left;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  interval_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tmr_wr_i(wr), .tmr_sel_i(sel),
    .tmr_wdata_i(wdata), .cnt_rd_i(rd), .count_o(count), .irq_o(irq),
    .clocks_left_o(left)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input int c, input int f, input int l, input string req);
    chk(int'(count), c, req, "count");
    chk(int'(irq[7]), f, req, "flag");
    chk(int'(left), l, req, "clocks_left");
    chk(int'(irq[6:0]), 0, "R10", "irq low bits");
  endtask

  function automatic int ratio(input int s);
    case (s)
      0: return 1;
      1: return 8;
      2: return 64;
      default: return 1024;
    endcase
  endfunction

  task automatic do_write(input int s, input int v);
    @(negedge clk);
    wr = 1'b1; sel = 2'(s); wdata = 8'(v);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // expected state k edges after a write edge, no reads
  task automatic sweep(input int s, input int v, input int extra);
    int d, ku, c, f, l;
    d  = ratio(s);
    ku = 1 + v * d;
    do_write(s, v);
    for (int k = 0; k <= ku + extra; k++) begin
      if (k > 0) @(negedge clk);
      if (k < ku) begin
        c = v - ((k == 0) ? 0 : ((k - 1) / d + 1));
        f = 0;
        l = (k == 0) ? 1 : d - ((k - 1) % d);
      end else begin
        c = (255 - (k - ku)) & 255;
        f = 1;
        l = 1;
      end
      if (k == 0) chk_all(c, f, l, "R2");
      else if (k < ku) chk_all(c, f, l, "R3");
      else if (k == ku) chk_all(c, f, l, "R4");
      else chk_all(c, f, l, "R5");
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    // R8 reset state
    chk_all(0, 0, 1024, "R8");
    step(1023);
    chk_all(0, 0, 1, "R8");
    step(1);
    chk_all(255, 1, 1, "R8");

    // R1 ratio sweeps
    for (int v = 0; v < 256; v++) sweep(0, v, 3);
    for (int v = 0; v < 32; v++) sweep(1, v, 3);
    for (int v = 0; v < 8; v++) sweep(2, v, 3);
    sweep(3, 0, 2);
    sweep(3, 1, 2);

    // R6/R7 read in wrapped mode: ratio 8, start 1, underflow at edge 9
    do_write(1, 1);
    step(12);
    chk_all(252, 1, 1, "R5");
    rd = 1'b1; @(negedge clk); rd = 1'b0;    // edge 13
    chk_all(251, 0, 4, "R7");
    step(3);                                  // edge 16
    chk_all(251, 0, 1, "R6");
    step(1);                                  // edge 17
    chk_all(250, 0, 8, "R6");

    // R7 read on the underflow edge: ratio 8, start 2, underflow at edge 17
    do_write(1, 2);
    step(16);
    chk_all(0, 0, 1, "R3");
    rd = 1'b1; @(negedge clk); rd = 1'b0;    // edge 17
    chk_all(255, 1, 8, "R7");
    step(7);                                  // edge 24
    chk_all(255, 1, 1, "R6");
    step(1);                                  // edge 25
    chk_all(254, 1, 8, "R6");
    rd = 1'b1; @(negedge clk); rd = 1'b0;    // edge 26
    chk_all(254, 0, 7, "R7");

    // R6 read before underflow leaves the count running normally
    do_write(1, 5);
    step(2);
    rd = 1'b1; @(negedge clk); rd = 1'b0;    // edge 3
    chk_all(4, 0, 6, "R6");
    step(6);                                  // edge 9
    chk_all(3, 0, 8, "R6");

    // R2 write while wrapped
    do_write(0, 0);
    step(4);
    chk_all(252, 1, 1, "R5");
    do_write(1, 3);
    chk_all(3, 0, 1, "R2");
    step(1);
    chk_all(2, 0, 8, "R2");

    // R11 write and read on one edge while the flag is set
    do_write(0, 0);
    step(2);
    chk_all(254, 1, 1, "R11");
    @(negedge clk);
    wr = 1'b1; rd = 1'b1; sel = 2'd0; wdata = 8'd7;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    chk_all(7, 0, 1, "R11");
    step(1);
    chk_all(6, 0, 1, "R11");

    // R1 select 3 restores 1024
    do_write(3, 4);
    step(1);
    chk_all(3, 0, 1024, "R1");

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 190000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule